// File: doc/BRIEF.md
# SPI Register Bus Bridge

This block is an SPI slave that turns framed transactions from a host microcontroller into reads and writes on a simple on-chip register bus. Chip select brackets each transaction. The first byte of a transaction is a command byte. It carries a target code and two enable bits, one for reading and one for writing. One or more address bytes follow, most significant byte first. A data burst of any length comes after the address. The link is full duplex: while each incoming byte is shifted in, a byte of read data is shifted out on MISO.

All SPI lines are synchronised into the system clock domain and handled in SPI mode 0. The register bus provides an address, write data, one-cycle write and read strobes, and a read-data input that the bus must present on the clock after the read strobe. Data words are 8 or 16 bits wide; a 16-bit word travels high byte first. After each word the bus address steps by one, so a burst covers consecutive registers. A frame whose target code differs from the configured one is ignored, and MISO stays undriven for the rest of that frame.

Top module: `spi_regbus_slave`

## Requirements
- R1: While chip select is high, spi_miso_oe, bus_we and bus_re are low. Each chip-select low period starts a new frame at the command byte, whatever state the previous frame was left in.
- R2: Command byte encoding is bits 7..2 = target code, bit 1 = read enable, bit 0 = write enable. A matching command with both enables clear produces no bus strobe.
- R3: If the target code differs from TARGET_CODE, the frame produces no bus_we and no bus_re, and spi_miso_oe drops after the command byte and stays low until chip select is released.
- R4: ADDR_BYTES address bytes follow the command byte, most significant byte first, and together form the start address of the burst.
- R5: SPI mode 0: MOSI is sampled on rising SCK and MISO changes only after falling SCK, MSB first. During the command and address bytes MISO sends zeros, with spi_miso_oe high from the start of the frame.
- R6: With write enable set, each complete data word produces exactly one single-cycle bus_we. bus_wdata holds the word, with the first received byte as the high byte when WORD_BITS is 16.
- R7: With read enable set, bus_re pulses for one cycle when the last address byte completes and again after each completed word (a read-ahead for the next word). bus_rdata is taken on the clock after bus_re. Each word is sent high byte first. With read enable clear, data bytes on MISO are zero.
- R8: Within a burst, bus_addr steps by one after each word and wraps at 2^(8*ADDR_BYTES).
- R9: A byte cut short by chip-select release is discarded, and so is an incomplete 16-bit word. Neither produces a bus_we.
- R10: With both enable bits set, each data word is written while read data for the same address goes out on MISO in the same burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | SPI serial clock from the host (asynchronous) |
| spi_cs_n | input | 1 | Active-low chip select from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for the MISO pad driver |
| bus_addr | output | 8*ADDR_BYTES | Register bus address |
| bus_wdata | output | WORD_BITS | Register bus write data |
| bus_we | output | 1 | Single-cycle write strobe |
| bus_re | output | 1 | Single-cycle read strobe |
| bus_rdata | input | WORD_BITS | Read data, valid the clock after bus_re |

## Verification
The assertions assume that the SCK high and low phases each last at least six system clocks. This leaves time for the read-ahead strobe and the capture of read data before the next falling edge. They also assume that chip select is not released within a few clocks of the last rising SCK edge. The stimulus holds each SCK phase for eight clocks and keeps chip select low for eight clocks on either side of the clock burst. The bench's bus model returns read data one clock after each strobe, which matches the timing the bridge expects.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;

  typedef enum logic [1:0] {
    PH_COMMAND = 2'd0,
    PH_ADDRESS = 2'd1,
    PH_DATA    = 2'd2,
    PH_IGNORE  = 2'd3
  } frame_phase_t;

  // Command byte layout: [7:2] target code, [1] read enable, [0] write enable.
  function automatic logic [5:0] cmd_target(input logic [7:0] cmd);
    return cmd[7:2];
  endfunction

  function automatic logic cmd_read(input logic [7:0] cmd);
    return cmd[1];
  endfunction

  function automatic logic cmd_write(input logic [7:0] cmd);
    return cmd[0];
  endfunction

  // Byte of a data word that goes on the wire at byte position idx.
  function automatic logic [7:0] word_byte(input logic [15:0] w,
                                           input logic two_bytes,
                                           input logic idx);
    return (two_bytes && !idx) ? w[15:8] : w[7:0];
  endfunction

endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic cs_n_i,
  input  logic mosi_i,
  output logic cs_act,
  output logic mosi_s,
  output logic sck_rise,
  output logic sck_fall
);
  localparam int LANES = 3;

  logic [LANES-1:0] raw;
  logic [LANES-1:0] synced;
  logic [LANES-1:0] idle_val;
  logic             sck_s;
  logic             sck_d;

  assign raw      = {sck_i, ~cs_n_i, mosi_i};
  assign idle_val = '0;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{idle_val[g]}};
      else        chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

  assign sck_s  = synced[2];
  assign cs_act = synced[1];
  assign mosi_s = synced[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= sck_s;
  end

  assign sck_rise = cs_act &  sck_s & ~sck_d;
  assign sck_fall = cs_act & ~sck_s &  sck_d;

endmodule

// File: rtl/spi_rb_shifter.sv
module spi_rb_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_act,
  input  logic       sck_rise,
  input  logic       sck_fall,
  input  logic       mosi_s,
  input  logic [7:0] tx_byte,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       miso
);
  logic [2:0] bit_cnt;
  logic [6:0] rx_sr;
  logic [7:0] tx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      rx_sr     <= '0;
      tx_sr     <= '0;
      rx_byte   <= '0;
      byte_done <= 1'b0;
    end else if (!cs_act) begin
      bit_cnt   <= '0;
      tx_sr     <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (sck_rise) begin
        rx_sr   <= {rx_sr[5:0], mosi_s};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_done <= 1'b1;
          rx_byte   <= {rx_sr, mosi_s};
        end
      end
      if (sck_fall) begin
        if (bit_cnt == 3'd0) tx_sr <= tx_byte;
        else                 tx_sr <= {tx_sr[6:0], 1'b0};
      end
    end
  end

  assign miso = tx_sr[7];

  a_r9_byte_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> $past(cs_act));

  a_r5_miso_holds_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    sck_rise |=> ($stable(miso) || !cs_act));

endmodule

// File: rtl/spi_rb_frame.sv
module spi_rb_frame
  import spi_rb_pkg::*;
#(
  parameter logic [5:0] TARGET_CODE = 6'h2A,
  parameter int         ADDR_BYTES  = 1,
  parameter int         WORD_BITS   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_act,
  input  logic                    byte_done,
  input  logic [7:0]              rx_byte,
  input  logic [WORD_BITS-1:0]    bus_rdata,
  output logic [8*ADDR_BYTES-1:0] bus_addr,
  output logic [WORD_BITS-1:0]    bus_wdata,
  output logic                    bus_we,
  output logic                    bus_re,
  output logic [7:0]              tx_byte,
  output logic                    drive_en
);
  localparam int   ADDR_W     = 8 * ADDR_BYTES;
  localparam int   WORD_BYTES = WORD_BITS / 8;
  localparam int   AB_W       = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam logic [AB_W-1:0] LAST_AB  = AB_W'(ADDR_BYTES - 1);
  localparam logic            LAST_IDX = 1'(WORD_BYTES - 1);
  localparam logic            TWO_BYTE = (WORD_BYTES == 2);

  frame_phase_t          phase_q;
  logic [AB_W-1:0]       ab_cnt_q;
  logic                  bidx_q;
  logic                  ren_q, wen_q;
  logic [ADDR_W-1:0]     addr_q;
  logic [WORD_BITS-1:0]  wbuf_q, wdata_q, rd_word_q;
  logic                  we_q, re_q, cap_q, step_q;

  logic [ADDR_W+7:0]     addr_cat;
  logic [ADDR_W-1:0]     addr_next;
  logic [WORD_BITS+7:0]  word_cat;
  logic [WORD_BITS-1:0]  word_next;
  logic                  cmd_match;
  logic                  word_done;
  logic                  addr_done;

  // Named events for the checks below.
  assign addr_cat  = {addr_q, rx_byte};
  assign addr_next = addr_cat[ADDR_W-1:0];
  assign word_cat  = {wbuf_q, rx_byte};
  assign word_next = word_cat[WORD_BITS-1:0];
  assign cmd_match = (cmd_target(rx_byte) == TARGET_CODE);
  assign word_done = byte_done && (phase_q == PH_DATA) && (bidx_q == LAST_IDX);
  assign addr_done = byte_done && (phase_q == PH_ADDRESS) && (ab_cnt_q == LAST_AB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_COMMAND;
      ab_cnt_q  <= '0;
      bidx_q    <= 1'b0;
      ren_q     <= 1'b0;
      wen_q     <= 1'b0;
      addr_q    <= '0;
      wbuf_q    <= '0;
      wdata_q   <= '0;
      rd_word_q <= '0;
      we_q      <= 1'b0;
      re_q      <= 1'b0;
      cap_q     <= 1'b0;
      step_q    <= 1'b0;
    end else begin
      we_q   <= 1'b0;
      re_q   <= 1'b0;
      step_q <= 1'b0;
      cap_q  <= re_q;
      if (cap_q) rd_word_q <= bus_rdata;
      if (step_q) begin
        addr_q <= addr_q + ADDR_W'(1);
        re_q   <= ren_q;
      end
      if (!cs_act) begin
        phase_q  <= PH_COMMAND;
        ab_cnt_q <= '0;
        bidx_q   <= 1'b0;
      end else if (byte_done) begin
        unique case (phase_q)
          PH_COMMAND: begin
            ren_q    <= cmd_read(rx_byte);
            wen_q    <= cmd_write(rx_byte);
            ab_cnt_q <= '0;
            bidx_q   <= 1'b0;
            phase_q  <= cmd_match ? PH_ADDRESS : PH_IGNORE;
          end
          PH_ADDRESS: begin
            addr_q <= addr_next;
            if (addr_done) begin
              phase_q <= PH_DATA;
              re_q    <= ren_q;
            end else begin
              ab_cnt_q <= ab_cnt_q + AB_W'(1);
            end
          end
          PH_DATA: begin
            wbuf_q <= word_next;
            if (word_done) begin
              bidx_q  <= 1'b0;
              we_q    <= wen_q;
              wdata_q <= word_next;
              step_q  <= 1'b1;
            end else begin
              bidx_q <= ~bidx_q;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;
  assign bus_we    = we_q;
  assign bus_re    = re_q;
  assign drive_en  = (phase_q != PH_IGNORE);
  assign tx_byte   = (phase_q == PH_DATA && ren_q)
                     ? word_byte(16'(rd_word_q), TWO_BYTE, bidx_q) : 8'h00;

  a_r6_we_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |=> !bus_we);

  a_r7_re_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re |=> !bus_re);

  a_r7_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_re));

  a_r8_addr_steps_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |-> ##2 (bus_addr == $past(bus_addr, 2) + ADDR_W'(1)));

  a_r3_ignored_frame_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IGNORE) |-> (!drive_en && !bus_we && !bus_re));

  a_r2_write_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> (bus_we == wen_q));

endmodule

// File: rtl/spi_regbus_slave.sv
module spi_regbus_slave #(
  parameter logic [5:0] TARGET_CODE = 6'h2A,
  parameter int         ADDR_BYTES  = 1,
  parameter int         WORD_BITS   = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    spi_sck,
  input  logic                    spi_cs_n,
  input  logic                    spi_mosi,
  output logic                    spi_miso,
  output logic                    spi_miso_oe,
  output logic [8*ADDR_BYTES-1:0] bus_addr,
  output logic [WORD_BITS-1:0]    bus_wdata,
  output logic                    bus_we,
  output logic                    bus_re,
  input  logic [WORD_BITS-1:0]    bus_rdata
);
  logic       cs_act, mosi_s, sck_rise, sck_fall;
  logic       byte_done, drive_en;
  logic [7:0] rx_byte, tx_byte;

  spi_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck_i    (spi_sck),
    .cs_n_i   (spi_cs_n),
    .mosi_i   (spi_mosi),
    .cs_act   (cs_act),
    .mosi_s   (mosi_s),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall)
  );

  spi_rb_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_act    (cs_act),
    .sck_rise  (sck_rise),
    .sck_fall  (sck_fall),
    .mosi_s    (mosi_s),
    .tx_byte   (tx_byte),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .miso      (spi_miso)
  );

  spi_rb_frame #(
    .TARGET_CODE (TARGET_CODE),
    .ADDR_BYTES  (ADDR_BYTES),
    .WORD_BITS   (WORD_BITS)
  ) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_act    (cs_act),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .bus_rdata (bus_rdata),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .tx_byte   (tx_byte),
    .drive_en  (drive_en)
  );

  assign spi_miso_oe = cs_act && drive_en;

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |-> !spi_miso_oe);

endmodule

// File: tb/sim_spi_regbus_slave.sv
`timescale 1ns/1ps
module sim_spi_regbus_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic sck = 1'b0, mosi = 1'b0, cs0_n = 1'b1, cs1_n = 1'b1;

  // u0: 16-bit words, 2 address bytes, code 0x15. u1: defaults, code 0x2A.
  logic        miso0, oe0, we0, re0;
  logic [15:0] addr0, wdata0, rdata0;
  logic        miso1, oe1, we1, re1;
  logic [7:0]  addr1, wdata1, rdata1;

  spi_regbus_slave #(.TARGET_CODE(6'h15), .ADDR_BYTES(2), .WORD_BITS(16)) u0 (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs0_n), .spi_mosi(mosi),
    .spi_miso(miso0), .spi_miso_oe(oe0), .bus_addr(addr0), .bus_wdata(wdata0),
    .bus_we(we0), .bus_re(re0), .bus_rdata(rdata0));

  spi_regbus_slave u1 (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs1_n), .spi_mosi(mosi),
    .spi_miso(miso1), .spi_miso_oe(oe1), .bus_addr(addr1), .bus_wdata(wdata1),
    .bus_we(we1), .bus_re(re1), .bus_rdata(rdata1));

  function automatic logic [7:0] f1(input logic [7:0] a);
    return 8'(a * 8'd29 + 8'h47);
  endfunction
  function automatic logic [15:0] f0(input logic [15:0] a);
    return 16'((a * 16'd257) ^ 16'hC35A);
  endfunction

  int w0cnt = 0, w1cnt = 0, r0cnt = 0, r1cnt = 0;
  logic [15:0] w0a [16], w0d [16];
  logic [7:0]  w1a [16], w1d [16];

  always_ff @(posedge clk) begin
    if (re0) begin rdata0 <= f0(addr0); r0cnt <= r0cnt + 1; end
    if (re1) begin rdata1 <= f1(addr1); r1cnt <= r1cnt + 1; end
    if (we0) begin w0a[w0cnt[3:0]] <= addr0; w0d[w0cnt[3:0]] <= wdata0; w0cnt <= w0cnt + 1; end
    if (we1) begin w1a[w1cnt[3:0]] <= addr1; w1d[w1cnt[3:0]] <= wdata1; w1cnt <= w1cnt + 1; end
  end

  int checks = 0, errors = 0;
  logic [7:0] tx_buf [16];
  logic [7:0] rx_buf [16];
  logic oe_first, oe_late_any, oe_late_all;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input int sel, input int nbytes, input int xbits);
    int total;
    int nb;
    logic [7:0] got;
    logic m, o;
    total = nbytes + ((xbits > 0) ? 1 : 0);
    oe_first = 1'b0; oe_late_any = 1'b0; oe_late_all = 1'b1;
    @(negedge clk);
    if (sel == 0) cs0_n = 1'b0; else cs1_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < total; i++) begin
      nb = (i < nbytes) ? 8 : xbits;
      got = 8'h00;
      for (int b = 0; b < nb; b++) begin
        mosi = tx_buf[i][7-b];
        repeat (8) @(negedge clk);
        m = (sel == 0) ? miso0 : miso1;
        o = (sel == 0) ? oe0 : oe1;
        got = {got[6:0], m};
        if (i == 0 && b == 0) oe_first = o;
        if (i > 0) begin oe_late_any |= o; oe_late_all &= o; end
        sck = 1'b1;
        repeat (8) @(negedge clk);
        sck = 1'b0;
      end
      if (i < nbytes) rx_buf[i] = got;
    end
    repeat (8) @(negedge clk);
    cs0_n = 1'b1; cs1_n = 1'b1;
    repeat (24) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int wb, rb;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset / idle state
    chk(!oe0 && !oe1, "R1 idle oe", {oe0, oe1}, 0);
    chk(!we0 && !we1, "R1 idle we", {we0, we1}, 0);
    chk(!re0 && !re1, "R1 idle re", {re0, re1}, 0);

    // R6 R8 write burst wrapping at 0xFF
    wb = w1cnt;
    tx_buf[0] = 8'hA9; tx_buf[1] = 8'hFE;
    tx_buf[2] = 8'h11; tx_buf[3] = 8'h22; tx_buf[4] = 8'h33; tx_buf[5] = 8'h44;
    xfer(1, 6, 0);
    chk(oe_first && oe_late_all, "R5 oe high in frame", {oe_first, oe_late_all}, 3);
    chk(w1cnt - wb == 4, "R6 write count", w1cnt - wb, 4);
    for (int k = 0; k < 4; k++) begin
      chk(w1a[(wb + k) % 16] == 8'(8'hFE + k), "R8 write addr", w1a[(wb + k) % 16], 8'(8'hFE + k));
      chk(w1d[(wb + k) % 16] == tx_buf[2 + k], "R6 write data", w1d[(wb + k) % 16], tx_buf[2 + k]);
    end
    for (int k = 0; k < 6; k++)
      chk(rx_buf[k] == 8'h00, "R7 zeros without read enable", rx_buf[k], 0);

    // R7 read burst
    wb = w1cnt;
    tx_buf[0] = 8'hAA; tx_buf[1] = 8'h10; tx_buf[2] = 0; tx_buf[3] = 0; tx_buf[4] = 0;
    xfer(1, 5, 0);
    chk(rx_buf[0] == 0 && rx_buf[1] == 0, "R5 zeros in header", {rx_buf[0], rx_buf[1]}, 0);
    for (int k = 0; k < 3; k++)
      chk(rx_buf[2 + k] == f1(8'(8'h10 + k)), "R7 read data", rx_buf[2 + k], f1(8'(8'h10 + k)));
    chk(w1cnt == wb, "R7 read-only makes no write", w1cnt - wb, 0);

    // R10 full duplex
    wb = w1cnt;
    tx_buf[0] = 8'hAB; tx_buf[1] = 8'h40; tx_buf[2] = 8'h5A; tx_buf[3] = 8'hA5;
    xfer(1, 4, 0);
    chk(rx_buf[2] == f1(8'h40) && rx_buf[3] == f1(8'h41), "R10 duplex read",
        {rx_buf[2], rx_buf[3]}, {f1(8'h40), f1(8'h41)});
    chk(w1cnt - wb == 2 && w1a[wb % 16] == 8'h40 && w1d[(wb + 1) % 16] == 8'hA5,
        "R10 duplex write", w1d[(wb + 1) % 16], 8'hA5);

    // R3 target mismatch
    wb = w1cnt; rb = r1cnt;
    tx_buf[0] = 8'h57; tx_buf[1] = 8'h10; tx_buf[2] = 8'h99; tx_buf[3] = 8'h88;
    xfer(1, 4, 0);
    chk(!oe_late_any, "R3 oe low after mismatch", oe_late_any, 0);
    chk(w1cnt == wb && r1cnt == rb, "R3 no strobes", (w1cnt - wb) + (r1cnt - rb), 0);

    // R2 neither enable bit
    wb = w1cnt; rb = r1cnt;
    tx_buf[0] = 8'hA8; tx_buf[1] = 8'h50; tx_buf[2] = 8'h12;
    xfer(1, 3, 0);
    chk(w1cnt == wb && r1cnt == rb, "R2 no enables no strobes", (w1cnt - wb) + (r1cnt - rb), 0);

    // R4 R6 16-bit words, two address bytes
    wb = w0cnt;
    tx_buf[0] = 8'h55; tx_buf[1] = 8'h12; tx_buf[2] = 8'h34;
    tx_buf[3] = 8'hDE; tx_buf[4] = 8'hAD; tx_buf[5] = 8'hBE; tx_buf[6] = 8'hEF;
    xfer(0, 7, 0);
    chk(w0cnt - wb == 2, "R6 16-bit write count", w0cnt - wb, 2);
    chk(w0a[wb % 16] == 16'h1234, "R4 address MSB first", w0a[wb % 16], 16'h1234);
    chk(w0d[wb % 16] == 16'hDEAD, "R6 high byte first", w0d[wb % 16], 16'hDEAD);
    chk(w0a[(wb + 1) % 16] == 16'h1235 && w0d[(wb + 1) % 16] == 16'hBEEF, "R8 16-bit step",
        w0d[(wb + 1) % 16], 16'hBEEF);

    // R7 R8 16-bit read across a byte boundary
    tx_buf[0] = 8'h56; tx_buf[1] = 8'hAB; tx_buf[2] = 8'hFF;
    for (int k = 3; k < 7; k++) tx_buf[k] = 8'h00;
    xfer(0, 7, 0);
    chk({rx_buf[3], rx_buf[4]} == f0(16'hABFF), "R7 16-bit read", {rx_buf[3], rx_buf[4]}, f0(16'hABFF));
    chk({rx_buf[5], rx_buf[6]} == f0(16'hAC00), "R8 read increment", {rx_buf[5], rx_buf[6]}, f0(16'hAC00));

    // R9 partial byte dropped, R1 next frame restarts cleanly
    wb = w1cnt;
    tx_buf[0] = 8'hA9; tx_buf[1] = 8'h20; tx_buf[2] = 8'h77; tx_buf[3] = 8'hF0;
    xfer(1, 3, 4);
    chk(w1cnt - wb == 1 && w1d[wb % 16] == 8'h77, "R9 partial byte dropped", w1cnt - wb, 1);
    wb = w1cnt;
    tx_buf[0] = 8'hA9; tx_buf[1] = 8'h30; tx_buf[2] = 8'h66;
    xfer(1, 3, 0);
    chk(w1cnt - wb == 1 && w1a[wb % 16] == 8'h30 && w1d[wb % 16] == 8'h66,
        "R1 new frame after abort", w1a[wb % 16], 8'h30);

    // R9 incomplete 16-bit word
    wb = w0cnt;
    tx_buf[0] = 8'h55; tx_buf[1] = 8'h00; tx_buf[2] = 8'h10; tx_buf[3] = 8'hAA;
    xfer(0, 4, 0);
    chk(w0cnt == wb, "R9 half word dropped", w0cnt - wb, 0);
    chk(!oe0 && !oe1 && !we0 && !re0, "R1 quiet after frames", {oe0, oe1, we0, re0}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule